// File: doc/BRIEF.md
# Autocorrelation Normalization Unit

This block turns the raw correlation sums of a group of pixels into normalized per-lag correlation values once an integration period closes. For every pixel it fetches the summed photon count and the sixteen per-lag product sums through the spare port of the autocorrelator memory. It squares the count and divides each product sum by that square in four parallel pipelined dividers. One pixel therefore retires in four result beats, each beat carrying four adjacent lags.

A pass begins with a start pulse. From then on the unit reads a pixel only after the accumulating logic reports that pixel as finished. Normalization of early pixels thus overlaps the final frame update of later ones, and the group is done before the next period needs the memory. Scaling by the frame count is left to later software. A route select taken at the start of the pass sends every beat either to the ensemble column adder or out on a per-pixel debug stream.

Top module: `acn_norm_unit`

## Requirements
- R1: While reset is held and after its release, `rd_en`, `busy`, `ens_valid` and `dbg_valid` are low until a pass is started.
- R2: Each result lane equals floor(P * 2^16 / S^2) as unsigned fixed point with 16 fractional bits. P is the lane's lag product sum and S is the pixel's count sum. A quotient of 2^32 or more saturates to 32'hFFFFFFFF.
- R3: A pixel whose count sum is zero yields 0 in every lane and raises `res_zero` on each of its beats. Otherwise `res_zero` is low.
- R4: Memory layout, with five rows per pixel: row 5p holds the count sum of pixel p in bits [15:0]. Row 5p+1+r holds lag 4r+i in lane i, at bits [32i+31:32i]. `rd_data` is returned one cycle after `rd_en`.
- R5: A result beat appears exactly 21 cycles after the `rd_en` cycle that fetched its row (a 20-cycle divider plus one memory cycle).
- R6: With every pixel ready, a pass reads on 480 consecutive cycles without a gap, and `rd_en` is only high while `busy` is high.
- R7: Beats come in ascending pixel order with lags 0, 4, 8, 12 on consecutive cycles for each pixel. The lag tag names lane 0, and `res_pixel` names the pixel.
- R8: `dbg_mode` sampled at the accepted start selects the route: 1 gives `dbg_valid` and 0 gives `ens_valid`. A change of `dbg_mode` during a pass has no effect on that pass.
- R9: `start` is accepted only when `busy` is low. A start pulse during a pass neither restarts nor repeats any beat, and the pass still delivers exactly 384 beats.
- R10: Pixel p is never read while `ready_cnt` is p or less. With `ready_cnt` at zero, no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a normalization pass |
| dbg_mode | input | 1 | Route select, sampled at accepted start |
| ready_cnt | input | 7 | Number of pixels that have finished the period |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 9 | Memory row address |
| rd_data | input | 128 | Memory row, returned one cycle after rd_en |
| busy | output | 1 | Pass in progress or results still in flight |
| ens_valid | output | 1 | Beat for the ensemble adder |
| dbg_valid | output | 1 | Beat on the debug stream |
| res_pixel | output | 7 | Pixel index of the beat |
| res_lag | output | 4 | Lag of lane 0 of the beat |
| res_data | output | 128 | Four normalized lag values |
| res_zero | output | 1 | Count sum of this pixel was zero |

## Verification
The fetch of a later pixel and the retirement of results for an earlier pixel land in the same cycle throughout every pass. The bench also makes a start pulse and a route change arrive while the group is still being fetched under a slowly rising ready count. Each beat is compared lane by lane against a bench-side division of the memory contents. The bench checks that the pixel and lag sequence stays unbroken, that the route never switches mid-pass, and that no row is read ahead of the ready count.

// File: rtl/acn_pkg.sv
package acn_pkg;

    typedef enum logic {
        ROUTE_ENSEMBLE = 1'b0,
        ROUTE_DEBUG    = 1'b1
    } route_e;

endpackage

// File: rtl/acn_div.sv
// Fixed-latency restoring divider, BPS quotient bits per stage.
module acn_div #(
    parameter int NUMW = 48,
    parameter int DENW = 32,
    parameter int LAT  = 20,
    localparam int BPS  = (NUMW + LAT - 1) / LAT,
    localparam int PADW = BPS * LAT
) (
    input  logic            clk,
    input  logic [NUMW-1:0] num,
    input  logic [DENW-1:0] den,
    output logic [PADW-1:0] quo
);

    typedef struct packed {
        logic [DENW:0]   rem;
        logic [PADW-1:0] num;
        logic [PADW-1:0] quo;
        logic [DENW-1:0] den;
    } stage_t;

    stage_t st_d [LAT];
    stage_t st_q [LAT];

    always_comb begin
        for (int s = 0; s < LAT; s++) begin
            stage_t cur;
            if (s == 0) begin
                cur.rem = '0;
                cur.num = PADW'(num);
                cur.quo = '0;
                cur.den = den;
            end else begin
                cur = st_q[s-1];
            end
            for (int b = 0; b < BPS; b++) begin
                cur.rem = {cur.rem[DENW-1:0], cur.num[PADW-1]};
                cur.num = {cur.num[PADW-2:0], 1'b0};
                if (cur.rem >= {1'b0, cur.den}) begin
                    cur.rem = cur.rem - {1'b0, cur.den};
                    cur.quo = {cur.quo[PADW-2:0], 1'b1};
                end else begin
                    cur.quo = {cur.quo[PADW-2:0], 1'b0};
                end
            end
            st_d[s] = cur;
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < LAT; s++) begin
            st_q[s] <= st_d[s];
        end
    end

    assign quo = st_q[LAT-1].quo;

endmodule

// File: rtl/acn_fetch.sv
// Read sequencer: one pixel per ROWS cycles, gated by the ready count.
module acn_fetch #(
    parameter int NPIX = 96,
    parameter int ROWS = 5,
    localparam int AW   = $clog2(NPIX * ROWS),
    localparam int PIXW = $clog2(NPIX),
    localparam int CNTW = $clog2(NPIX + 1),
    localparam int RW   = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [CNTW-1:0] ready_cnt,
    output logic            rd_en,
    output logic [AW-1:0]   rd_addr,
    output logic            run,
    output logic            ret_vld,
    output logic [RW-1:0]   ret_row,
    output logic [PIXW-1:0] ret_pix
);

    typedef struct packed {
        logic            run;
        logic [PIXW-1:0] pix;
        logic [RW-1:0]   row;
        logic [AW-1:0]   base;
        logic            rv;
        logic [RW-1:0]   rrow;
        logic [PIXW-1:0] rpix;
    } fetch_t;

    fetch_t f_d, f_q;

    always_comb begin
        f_d     = f_q;
        f_d.rv  = 1'b0;
        rd_en   = 1'b0;
        rd_addr = f_q.base + AW'(f_q.row);
        if (go) begin
            f_d.run  = 1'b1;
            f_d.pix  = '0;
            f_d.row  = '0;
            f_d.base = '0;
        end else if (f_q.run && (f_q.row != '0 || CNTW'(f_q.pix) < ready_cnt)) begin
            rd_en    = 1'b1;
            f_d.rv   = 1'b1;
            f_d.rrow = f_q.row;
            f_d.rpix = f_q.pix;
            if (f_q.row == RW'(ROWS - 1)) begin
                f_d.row  = '0;
                f_d.base = f_q.base + AW'(ROWS);
                if (f_q.pix == PIXW'(NPIX - 1)) begin
                    f_d.run = 1'b0;
                end else begin
                    f_d.pix = f_q.pix + 1'b1;
                end
            end else begin
                f_d.row = f_q.row + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign run     = f_q.run;
    assign ret_vld = f_q.rv;
    assign ret_row = f_q.rrow;
    assign ret_pix = f_q.rpix;

endmodule

// File: rtl/acn_norm_unit.sv
module acn_norm_unit
    import acn_pkg::*;
#(
    parameter int NPIX    = 96,
    parameter int LAGS    = 16,
    parameter int LANES   = 4,
    parameter int DW      = 32,
    parameter int CW      = 16,
    parameter int FRAC    = 16,
    parameter int QW      = 32,
    parameter int DIV_LAT = 20,
    localparam int ROUNDS = LAGS / LANES,
    localparam int ROWS   = 1 + ROUNDS,
    localparam int AW     = $clog2(NPIX * ROWS),
    localparam int PIXW   = $clog2(NPIX),
    localparam int CNTW   = $clog2(NPIX + 1),
    localparam int LAGW   = $clog2(LAGS),
    localparam int RW     = $clog2(ROWS),
    localparam int DENW   = 2 * CW,
    localparam int NUMW   = DW + FRAC,
    localparam int PADW   = ((NUMW + DIV_LAT - 1) / DIV_LAT) * DIV_LAT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  dbg_mode,
    input  logic [CNTW-1:0]       ready_cnt,
    output logic                  rd_en,
    output logic [AW-1:0]         rd_addr,
    input  logic [LANES*DW-1:0]   rd_data,
    output logic                  busy,
    output logic                  ens_valid,
    output logic                  dbg_valid,
    output logic [PIXW-1:0]       res_pixel,
    output logic [LAGW-1:0]       res_lag,
    output logic [LANES*QW-1:0]   res_data,
    output logic                  res_zero
);

    typedef struct packed {
        logic            vld;
        logic [PIXW-1:0] pix;
        logic [LAGW-1:0] lag;
        logic            zero;
    } tag_t;

    typedef struct packed {
        route_e          route;
        logic [DENW-1:0] sq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    tag_t tag_d [DIV_LAT];
    tag_t tag_q [DIV_LAT];

    logic            go;
    logic            run;
    logic            ret_vld;
    logic [RW-1:0]   ret_row;
    logic [PIXW-1:0] ret_pix;
    logic            inflight;
    logic [CW-1:0]   cnt;

    acn_fetch #(
        .NPIX (NPIX),
        .ROWS (ROWS)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .ready_cnt (ready_cnt),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .run       (run),
        .ret_vld   (ret_vld),
        .ret_row   (ret_row),
        .ret_pix   (ret_pix)
    );

    assign cnt = rd_data[CW-1:0];

    always_comb begin
        inflight = 1'b0;
        for (int i = 0; i < DIV_LAT; i++) begin
            inflight = inflight | tag_q[i].vld;
        end
        busy = run | inflight;
        go   = start & ~busy;

        ctl_d = ctl_q;
        if (go) begin
            ctl_d.route = route_e'(dbg_mode);
        end
        if (ret_vld && ret_row == '0) begin
            ctl_d.sq = DENW'(cnt) * DENW'(cnt);
        end

        tag_d[0].vld  = ret_vld && ret_row != '0;
        tag_d[0].pix  = ret_pix;
        tag_d[0].lag  = LAGW'((int'(ret_row) - 1) * LANES);
        tag_d[0].zero = (ctl_q.sq == '0);
        for (int i = 1; i < DIV_LAT; i++) begin
            tag_d[i] = tag_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < DIV_LAT; i++) begin
                tag_q[i] <= '0;
            end
        end else begin
            ctl_q <= ctl_d;
            for (int i = 0; i < DIV_LAT; i++) begin
                tag_q[i] <= tag_d[i];
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [PADW-1:0] quo;

        acn_div #(
            .NUMW (NUMW),
            .DENW (DENW),
            .LAT  (DIV_LAT)
        ) u_div (
            .clk (clk),
            .num ({rd_data[l*DW +: DW], {FRAC{1'b0}}}),
            .den (ctl_q.sq),
            .quo (quo)
        );

        always_comb begin
            if (tag_q[DIV_LAT-1].zero) begin
                res_data[l*QW +: QW] = '0;
            end else if (|quo[PADW-1:QW]) begin
                res_data[l*QW +: QW] = '1;
            end else begin
                res_data[l*QW +: QW] = quo[QW-1:0];
            end
        end
    end

    assign ens_valid = tag_q[DIV_LAT-1].vld && ctl_q.route == ROUTE_ENSEMBLE;
    assign dbg_valid = tag_q[DIV_LAT-1].vld && ctl_q.route == ROUTE_DEBUG;
    assign res_pixel = tag_q[DIV_LAT-1].pix;
    assign res_lag   = tag_q[DIV_LAT-1].lag;
    assign res_zero  = tag_q[DIV_LAT-1].zero;

endmodule

// File: rtl/acn_norm_chk.sv
module acn_norm_chk #(
    parameter int NPIX  = 96,
    parameter int LAGS  = 16,
    parameter int LANES = 4,
    localparam int ROWS = 1 + LAGS / LANES,
    localparam int AW   = $clog2(NPIX * ROWS),
    localparam int PIXW = $clog2(NPIX),
    localparam int CNTW = $clog2(NPIX + 1),
    localparam int LAGW = $clog2(LAGS)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [CNTW-1:0] ready_cnt,
    input logic            rd_en,
    input logic [AW-1:0]   rd_addr,
    input logic            busy,
    input logic            ens_valid,
    input logic            dbg_valid,
    input logic [PIXW-1:0] res_pixel,
    input logic [LAGW-1:0] res_lag
);

    logic res_valid;
    assign res_valid = ens_valid | dbg_valid;

    // R10
    read_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_addr) / ROWS) < int'(ready_cnt));

    // R6
    read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);

    // R8
    route_dbg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_valid |=> !ens_valid);

    // R8
    route_ens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ens_valid |=> !dbg_valid);

    // R9
    start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R7
    lag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && int'(res_lag) != LAGS - LANES) |=>
        (res_valid && int'(res_lag) == int'($past(res_lag)) + LANES
                   && res_pixel == $past(res_pixel)));

endmodule

bind acn_norm_unit acn_norm_chk #(
    .NPIX  (NPIX),
    .LAGS  (LAGS),
    .LANES (LANES)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ready_cnt (ready_cnt),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .busy      (busy),
    .ens_valid (ens_valid),
    .dbg_valid (dbg_valid),
    .res_pixel (res_pixel),
    .res_lag   (res_lag)
);

// File: tb/test_acn_norm_unit.sv
`timescale 1ns/1ps
module test_acn_norm_unit;

    localparam int NPIX   = 96;
    localparam int LAGS   = 16;
    localparam int LANES  = 4;
    localparam int DW     = 32;
    localparam int QW     = 32;
    localparam int ROUNDS = LAGS / LANES;
    localparam int ROWS   = 1 + ROUNDS;
    localparam int BEATS  = NPIX * ROUNDS;
    localparam int DLAT   = 20;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic                 dbg_mode = 1'b0;
    logic [6:0]           ready_cnt = '0;
    logic                 rd_en;
    logic [8:0]           rd_addr;
    logic [LANES*DW-1:0]  rd_data = '0;
    logic                 busy;
    logic                 ens_valid;
    logic                 dbg_valid;
    logic [6:0]           res_pixel;
    logic [3:0]           res_lag;
    logic [LANES*QW-1:0]  res_data;
    logic                 res_zero;

    logic [LANES*DW-1:0]  mem [NPIX*ROWS];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_beat, rd_cnt, first_rd, last_rd, lat_rd, first_out, r10_viol;
    bit mode_exp;

    always #10 clk = ~clk;

    acn_norm_unit i_acn_norm_unit (
        .clk (clk), .rst_n (rst_n), .start (start), .dbg_mode (dbg_mode),
        .ready_cnt (ready_cnt), .rd_en (rd_en), .rd_addr (rd_addr),
        .rd_data (rd_data), .busy (busy), .ens_valid (ens_valid),
        .dbg_valid (dbg_valid), .res_pixel (res_pixel), .res_lag (res_lag),
        .res_data (res_data), .res_zero (res_zero)
    );

    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_q(input logic [15:0] c, input logic [31:0] pa);
        longint unsigned sq, q;
        sq = longint'(c) * longint'(c);
        if (sq == 0) return 32'h0;
        q = (longint'(pa) << 16) / sq;
        if (q > 64'hFFFF_FFFF) return 32'hFFFF_FFFF;
        return q[31:0];
    endfunction

    task automatic check_beat();
        int ep, el;
        logic [15:0] c;
        ep = exp_beat / ROUNDS;
        el = (exp_beat % ROUNDS) * LANES;
        chk(int'(res_pixel) == ep && int'(res_lag) == el, "R7", "pixel/lag",
            {res_pixel, res_lag}, (ep << 4) | el);
        chk(dbg_valid == mode_exp, "R8", "route", dbg_valid, mode_exp);
        if (ep < NPIX) begin
            c = mem[ep*ROWS][15:0];
            chk(res_zero == (c == 0), "R3", "zero flag", res_zero, c == 0);
            for (int l = 0; l < LANES; l++) begin
                logic [31:0] e;
                e = ref_q(c, mem[ep*ROWS + 1 + el/LANES][l*DW +: DW]);
                chk(res_data[l*QW +: QW] == e, (c == 0) ? "R3" : "R2", "lane value",
                    res_data[l*QW +: QW], e);
            end
        end
        exp_beat++;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_en) begin
                rd_cnt++;
                if (first_rd < 0) first_rd = cyc;
                last_rd = cyc;
                if (rd_addr == 9'd1 && lat_rd < 0) lat_rd = cyc;
                if (int'(rd_addr) / ROWS >= int'(ready_cnt)) r10_viol++;
            end
            if (ens_valid || dbg_valid) begin
                if (first_out < 0) first_out = cyc;
                check_beat();
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic fill_random();
        for (int p = 0; p < NPIX; p++) begin
            logic [15:0] c;
            longint unsigned sq;
            c = ($urandom % 8 == 0) ? 16'd0 : 16'(1 + $urandom % 300);
            sq = longint'(c) * longint'(c);
            mem[p*ROWS] = {96'(0), 16'($urandom), c};
            for (int r = 1; r < ROWS; r++) begin
                for (int l = 0; l < LANES; l++) begin
                    logic [31:0] pa;
                    if ($urandom % 4 == 0) pa = $urandom;
                    else pa = 32'((longint'($urandom % 4096) * sq) / 1024);
                    mem[p*ROWS + r][l*DW +: DW] = pa;
                end
            end
        end
    endtask

    task automatic fill_corner();
        for (int p = 0; p < NPIX; p++) begin
            logic [15:0] c;
            case (p % 4)
                0: c = 16'd0;
                1: c = 16'd1;
                2: c = 16'hFFFF;
                default: c = 16'd256;
            endcase
            mem[p*ROWS] = {112'(0), c};
            for (int r = 1; r < ROWS; r++) begin
                for (int l = 0; l < LANES; l++) begin
                    logic [31:0] pa;
                    case (p % 4)
                        0: pa = $urandom;
                        1: pa = (l == 0) ? 32'h0000_FFFF : 32'hFFFF_0000 | 32'(l);
                        2: pa = 32'(l * 1000);
                        default: pa = (l % 2 == 0) ? 32'h0001_0000 : 32'h0000_FFFF;
                    endcase
                    mem[p*ROWS + r][l*DW +: DW] = pa;
                end
            end
        end
    endtask

    task automatic begin_pass(input bit mode, input logic [6:0] rc);
        @(posedge clk); #2;
        exp_beat = 0; rd_cnt = 0; first_rd = -1; last_rd = -1;
        lat_rd = -1; first_out = -1; r10_viol = 0;
        mode_exp = mode;
        dbg_mode = mode;
        ready_cnt = rc;
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    task automatic finish_pass();
        do begin @(posedge clk); #2; end while (busy);
        repeat (3) @(posedge clk);
        #2;
        chk(exp_beat == BEATS, "R9", "beats per pass", exp_beat, BEATS);
        chk(first_out - lat_rd == DLAT + 1, "R5", "read-to-result latency",
            first_out - lat_rd, DLAT + 1);
        chk(r10_viol == 0, "R10", "reads ahead of ready", r10_viol, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        fill_random();
        repeat (4) @(posedge clk);
        #2;
        // R1: reset state
        chk(!rd_en && !busy && !ens_valid && !dbg_valid, "R1", "outputs in reset",
            {rd_en, busy, ens_valid, dbg_valid}, 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        chk(!rd_en && !busy && !ens_valid && !dbg_valid, "R1", "outputs after reset",
            {rd_en, busy, ens_valid, dbg_valid}, 0);

        // Pass A: ensemble route, all pixels ready (R2, R4, R5, R6, R7)
        begin_pass(1'b0, 7'(NPIX));
        finish_pass();
        chk(rd_cnt == NPIX * ROWS, "R6", "read count", rd_cnt, NPIX * ROWS);
        chk(last_rd - first_rd + 1 == NPIX * ROWS, "R6", "read span without gaps",
            last_rd - first_rd + 1, NPIX * ROWS);

        // Pass B: debug route, ready count ramps, disturbances mid-pass
        fill_random();
        begin_pass(1'b1, 7'd0);
        repeat (30) @(posedge clk);
        #2;
        chk(rd_cnt == 0, "R10", "no read with zero ready", rd_cnt, 0);
        for (int k = 1; k <= NPIX; k++) begin
            ready_cnt = 7'(k);
            if (k == 40) dbg_mode = 1'b0;   // R8: mid-pass route change
            if (k == 50) start = 1'b1;      // R9: start while busy
            @(posedge clk); #2;
            start = 1'b0;
            repeat (5) @(posedge clk);
            #2;
        end
        finish_pass();

        // Pass C: directed corners (saturation, zero sum, exact unity)
        fill_corner();
        begin_pass(1'b0, 7'(NPIX));
        finish_pass();
        chk(!busy && !ens_valid && !dbg_valid, "R1", "idle after pass",
            {busy, ens_valid, dbg_valid}, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule